// File: doc/BRIEF.md
# Expansion Card Autoconfiguration Responder

This block is the plug-and-play identification logic of an expansion card. After bus reset the card is unconfigured. The host reads the card's identity from a small configuration space. Each ID byte is returned as two 4-bit reads. The host then either assigns a base address or tells the card to shut up. Once configured, the card's decoded window becomes usable and the peripheral chip selects are enabled. Once shut up, the card never answers again until the next bus reset. In both cases the card passes configuration on to the next card in the chain.

The card runs in one of two bus modes. The narrow 16-bit mode claims a 64 KiB window. The wide 32-bit mode claims a 64 MiB window with a 64 KiB sub-size. Wide mode is used only when the slot reports that it is wide-capable and the mode jumper is open. If the host places a wide-mode card at or above 0x8000_0000, the card shuts itself up and raises a flag that software can read.

Top module: `autocfg_responder`

## Requirements
- R1: The product code 100 (0x64) is stored inverted at byte slot 1. The host reads 0x9 at offset 0x04 and 0xB at offset 0x06. The vendor code 4626 (0x1212) is stored inverted in slots 4 and 5. The host reads 0xE, 0xD, 0xE, 0xD at offsets 0x10, 0x12, 0x14 and 0x16.
- R2: Byte slot k occupies offsets 4k (high nibble) and 4k+2 (low nibble). The type byte in slot 0 is not inverted. Its value is 0xC1 in narrow mode (64 KiB) and 0x80 in wide mode (64 MiB, extended size). The flags byte in slot 2 is stored inverted. Its value is 0x22 in wide mode (extended-size bit 5 set, 64 KiB sub-size code 2) and 0x00 in narrow mode.
- R3: The 32-bit serial number is a parameter, default 12. It is stored inverted, most significant byte first, in slots 6 to 9. With the default, the host reads 0xF at offset 0x24 and 0x3 at offset 0x26. Every other offset reads 0xF.
- R4: Wide mode is selected only when `slot_wide` is 1 and `jumper_narrow` is 0. A closed jumper forces narrow mode even in a wide-capable slot.
- R5: In narrow mode, a write to offset 0x48 configures the card. The base A31..A16 becomes {8'h00, wdata[7:0]}. A write to 0x44 in narrow mode has no effect.
- R6: In wide mode, a write to offset 0x44 with wdata[15] = 0 configures the card. The base A31..A16 becomes wdata. A write to 0x48 in wide mode has no effect.
- R7: In wide mode, a write to 0x44 with wdata[15] = 1 shuts the card up and sets `hi_base_flag` instead of configuring it. In narrow mode, the same data value at offset 0x48 configures the card normally.
- R8: A write to offset 0x4C shuts the card up permanently. Later writes do not configure it.
- R9: A configuration read is acknowledged one clock after the read strobe, while the card is unconfigured. Once the card is configured or shut up, reads get no acknowledge.
- R10: `periph_en` is 0 until the card is configured, and it stays 0 when the card is shut up.
- R11: `chain_out` is 1 exactly when the card is configured or shut up.
- R12: Only bus reset leaves the configured or shut-up state. A second base write does not change the assigned base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| slot_wide | input | 1 | Slot reports that it is wide-capable |
| jumper_narrow | input | 1 | Closed jumper forces narrow mode |
| bus_rd | input | 1 | Configuration read strobe, one cycle |
| bus_wr | input | 1 | Configuration write strobe, one cycle |
| bus_addr | input | 8 | Byte offset in configuration space |
| bus_wdata | input | 16 | Write data |
| rd_ack | output | 1 | Read acknowledge, one clock after bus_rd |
| rd_nibble | output | 4 | Read data nibble |
| wide_mode | output | 1 | Bus mode in effect |
| configured | output | 1 | A base address has been assigned |
| shut_up | output | 1 | The card is permanently off the bus |
| hi_base_flag | output | 1 | The shutup was caused by a high wide base |
| base_addr | output | 16 | Assigned base A31..A16 |
| periph_en | output | 1 | Peripheral chip selects are enabled |
| chain_out | output | 1 | Configuration passed to the next card |

## Verification
The ID space is read in three mode settings: a narrow slot, a wide slot, and a wide slot with the jumper closed. The type and flags nibbles differ between these settings, so they show whether the jumper override works. Base writes go to both base offsets in each mode. This shows whether the write port is decoded by mode. A high wide base is compared with the same data value in narrow mode, which separates the automatic shutup from the normal configure path. A repeated base write, an explicit shutup followed by a base write, and reads after configuration confirm that the states are sticky and that the configuration space goes silent.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;
  typedef enum logic [1:0] {
    ST_UNCFG = 2'd0,
    ST_CONF  = 2'd1,
    ST_SHUT  = 2'd2
  } ac_state_e;

  localparam logic [7:0] OFS_BASE_WIDE   = 8'h44;
  localparam logic [7:0] OFS_BASE_NARROW = 8'h48;
  localparam logic [7:0] OFS_SHUTUP      = 8'h4C;

  localparam int unsigned SLOT_TYPE   = 0;
  localparam int unsigned SLOT_PROD   = 1;
  localparam int unsigned SLOT_FLAGS  = 2;
  localparam int unsigned SLOT_VEND   = 4;
  localparam int unsigned SLOT_SERIAL = 6;
endpackage

// File: rtl/autocfg_rom.sv
module autocfg_rom
  import autocfg_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter logic [7:0]  PRODUCT = 8'd100,
  parameter logic [15:0] VENDOR  = 16'd4626,
  parameter logic [31:0] SERIAL  = 32'd12
) (
  input  logic [AW-1:0] addr,
  input  logic          wide,
  output logic [3:0]    nibble
);
  localparam int unsigned SLOT_W = AW - 2;
  localparam int unsigned SER_BYTES = 4;

  logic [SLOT_W-1:0] slot;
  logic [7:0]        raw;
  logic [7:0]        ser_bytes [SER_BYTES];
  logic [7:0]        stored;

  assign slot = addr[AW-1:2];

  genvar g;
  generate
    for (g = 0; g < SER_BYTES; g++) begin : g_ser
      assign ser_bytes[g] = SERIAL[8*(SER_BYTES-1-g) +: 8];
    end
  endgenerate

  always_comb begin
    raw = 8'h00;
    if (slot == SLOT_W'(SLOT_TYPE)) begin
      raw = wide ? 8'h80 : 8'hC1;
    end else if (slot == SLOT_W'(SLOT_PROD)) begin
      raw = PRODUCT;
    end else if (slot == SLOT_W'(SLOT_FLAGS)) begin
      raw = wide ? 8'h22 : 8'h00;
    end else if (slot == SLOT_W'(SLOT_VEND)) begin
      raw = VENDOR[15:8];
    end else if (slot == SLOT_W'(SLOT_VEND + 1)) begin
      raw = VENDOR[7:0];
    end else begin
      for (int i = 0; i < SER_BYTES; i++) begin
        if (slot == SLOT_W'(SLOT_SERIAL + i)) raw = ser_bytes[i];
      end
    end
  end

  assign stored = (slot == SLOT_W'(SLOT_TYPE)) ? raw : ~raw;
  assign nibble = addr[1] ? stored[3:0] : stored[7:4];
endmodule

// File: rtl/autocfg_ctrl.sv
module autocfg_ctrl
  import autocfg_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          wide_q,
  output ac_state_e     state_q,
  output logic          hi_q,
  output logic [BW-1:0] base_q
);
  localparam int unsigned NB = 8;

  ac_state_e     state_d;
  logic          hi_d;
  logic [BW-1:0] base_d;
  logic          base_en;
  logic          is_wr;

  assign is_wr = bus_wr && (state_q == ST_UNCFG);

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    base_d  = base_q;
    base_en = 1'b0;
    if (is_wr) begin
      if (bus_addr == AW'(OFS_SHUTUP)) begin
        state_d = ST_SHUT;
      end else if (wide_q && bus_addr == AW'(OFS_BASE_WIDE)) begin
        if (bus_wdata[DW-1]) begin
          state_d = ST_SHUT;
          hi_d    = 1'b1;
        end else begin
          state_d = ST_CONF;
          base_d  = BW'(bus_wdata);
          base_en = 1'b1;
        end
      end else if (!wide_q && bus_addr == AW'(OFS_BASE_NARROW)) begin
        state_d = ST_CONF;
        base_d  = {{(BW-NB){1'b0}}, bus_wdata[NB-1:0]};
        base_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNCFG;
      hi_q    <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      if (state_q == ST_UNCFG) wide_q <= wide_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
  import autocfg_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned BW      = 16,
  parameter logic [7:0]  PRODUCT = 8'd100,
  parameter logic [15:0] VENDOR  = 16'd4626,
  parameter logic [31:0] SERIAL  = 32'd12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_wide,
  input  logic          jumper_narrow,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rd_ack,
  output logic [3:0]    rd_nibble,
  output logic          wide_mode,
  output logic          configured,
  output logic          shut_up,
  output logic          hi_base_flag,
  output logic [BW-1:0] base_addr,
  output logic          periph_en,
  output logic          chain_out
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  ac_state_e         state;
  logic              wide_q;
  logic [3:0]        rom_nib;
  logic              ack_d;
  logic              ack_q;
  logic [3:0]        nib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  autocfg_ctrl #(.AW(AW), .DW(DW), .BW(BW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wide_in   (slot_wide & ~jumper_narrow),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wide_q    (wide_q),
    .state_q   (state),
    .hi_q      (hi_base_flag),
    .base_q    (base_addr)
  );

  autocfg_rom #(.AW(AW), .PRODUCT(PRODUCT), .VENDOR(VENDOR), .SERIAL(SERIAL)) u_rom (
    .addr   (bus_addr),
    .wide   (wide_q),
    .nibble (rom_nib)
  );

  assign ack_d = bus_rd && (state == ST_UNCFG);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q <= 1'b0;
      nib_q <= 4'h0;
    end else begin
      ack_q <= ack_d;
      if (ack_d) nib_q <= rom_nib;
    end
  end

  assign rd_ack     = ack_q;
  assign rd_nibble  = nib_q;
  assign wide_mode  = wide_q;
  assign configured = (state == ST_CONF);
  assign shut_up    = (state == ST_SHUT);
  assign periph_en  = (state == ST_CONF);
  assign chain_out  = (state != ST_UNCFG);
endmodule

// File: rtl/autocfg_responder_chk.sv
module autocfg_responder_chk #(
  parameter int unsigned BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          rd_ack,
  input logic          configured,
  input logic          shut_up,
  input logic          hi_base_flag,
  input logic [BW-1:0] base_addr,
  input logic          periph_en,
  input logic          chain_out
);
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(configured && shut_up)); // R8

  AST_SILENT_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (configured || shut_up)) |=> !rd_ack); // R9

  AST_CONF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured); // R12

  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shut_up |=> shut_up); // R8

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> $stable(base_addr)); // R12

  AST_PERIPH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en |-> (configured && !shut_up)); // R10

  AST_CHAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_out |-> !(configured || shut_up)); // R11

  AST_HI_IMPLIES_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    hi_base_flag |-> shut_up); // R7
endmodule

bind autocfg_responder autocfg_responder_chk #(.BW(BW)) u_chk (.*);

// File: tb/autocfg_responder_bench.sv
module autocfg_responder_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_wide = 1'b0;
  logic        jumper_narrow = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic        rd_ack;
  logic [3:0]  rd_nibble;
  logic        wide_mode, configured, shut_up, hi_base_flag, periph_en, chain_out;
  logic [15:0] base_addr;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autocfg_responder u_autocfg_responder (
    .clk(clk), .rst_n(rst_n), .slot_wide(slot_wide), .jumper_narrow(jumper_narrow),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_ack(rd_ack), .rd_nibble(rd_nibble), .wide_mode(wide_mode),
    .configured(configured), .shut_up(shut_up), .hi_base_flag(hi_base_flag),
    .base_addr(base_addr), .periph_en(periph_en), .chain_out(chain_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic wide, input logic jmp);
    @(negedge clk);
    rst_n = 1'b0;
    slot_wide = wide;
    jumper_narrow = jmp;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] exp, input string tag);
    bus_addr = a;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " ack"}, 32'(rd_ack), 32'd1);
    check({tag, " nibble"}, 32'(rd_nibble), 32'(exp));
  endtask

  task automatic rd_silent(input logic [7:0] a, input string tag);
    bus_addr = a;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " no ack"}, 32'(rd_ack), 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    check("R11 chain_out after reset", 32'(chain_out), 32'd0);
    check("R10 periph_en after reset", 32'(periph_en), 32'd0);
    check("R12 configured after reset", 32'(configured), 32'd0);
    check("R8 shut_up after reset", 32'(shut_up), 32'd0);
    check("R9 rd_ack idle", 32'(rd_ack), 32'd0);
  endtask

  task automatic t_ids_narrow();
    do_reset(1'b0, 1'b0);
    check("R4 narrow slot mode", 32'(wide_mode), 32'd0);
    rd(8'h00, 4'hC, "R2 narrow type hi");
    rd(8'h02, 4'h1, "R2 narrow type lo");
    rd(8'h08, 4'hF, "R2 narrow flags hi");
    rd(8'h0A, 4'hF, "R2 narrow flags lo");
    rd(8'h04, 4'h9, "R1 product hi");
    rd(8'h06, 4'hB, "R1 product lo");
    rd(8'h10, 4'hE, "R1 vendor 0x10");
    rd(8'h12, 4'hD, "R1 vendor 0x12");
    rd(8'h14, 4'hE, "R1 vendor 0x14");
    rd(8'h16, 4'hD, "R1 vendor 0x16");
    rd(8'h18, 4'hF, "R3 serial 0x18");
    rd(8'h24, 4'hF, "R3 serial 0x24");
    rd(8'h26, 4'h3, "R3 serial 0x26");
    rd(8'h30, 4'hF, "R3 unused 0x30");
    rd(8'h0C, 4'hF, "R3 unused 0x0C");
  endtask

  task automatic t_ids_wide();
    do_reset(1'b1, 1'b0);
    check("R4 wide slot mode", 32'(wide_mode), 32'd1);
    rd(8'h00, 4'h8, "R2 wide type hi");
    rd(8'h02, 4'h0, "R2 wide type lo");
    rd(8'h08, 4'hD, "R2 wide flags hi");
    rd(8'h0A, 4'hD, "R2 wide flags lo");
    rd(8'h04, 4'h9, "R1 wide product hi");
  endtask

  task automatic t_jumper();
    do_reset(1'b1, 1'b1);
    check("R4 jumper forces narrow", 32'(wide_mode), 32'd0);
    rd(8'h00, 4'hC, "R4 jumper type hi");
    rd(8'h02, 4'h1, "R4 jumper type lo");
    wr(8'h48, 16'h00A5);
    check("R4 jumper narrow base write", 32'(configured), 32'd1);
  endtask

  task automatic t_narrow_cfg();
    do_reset(1'b0, 1'b0);
    wr(8'h44, 16'h1234);
    check("R5 narrow ignores 0x44", 32'(configured), 32'd0);
    check("R5 narrow 0x44 chain", 32'(chain_out), 32'd0);
    wr(8'h48, 16'h77E9);
    check("R5 narrow configured", 32'(configured), 32'd1);
    check("R5 narrow base", 32'(base_addr), 32'h00E9);
    check("R11 chain after config", 32'(chain_out), 32'd1);
    check("R10 periph after config", 32'(periph_en), 32'd1);
    rd_silent(8'h00, "R9 read after config");
    wr(8'h48, 16'h0011);
    check("R12 second base write", 32'(base_addr), 32'h00E9);
    wr(8'h4C, 16'h0000);
    check("R12 shutup after config", 32'(shut_up), 32'd0);
    check("R12 still configured", 32'(configured), 32'd1);
  endtask

  task automatic t_wide_cfg();
    do_reset(1'b1, 1'b0);
    wr(8'h48, 16'h0042);
    check("R6 wide ignores 0x48", 32'(configured), 32'd0);
    rd(8'h04, 4'h9, "R6 still readable");
    wr(8'h44, 16'h4000);
    check("R6 wide configured", 32'(configured), 32'd1);
    check("R6 wide base", 32'(base_addr), 32'h4000);
    check("R7 low base no flag", 32'(hi_base_flag), 32'd0);
    check("R10 wide periph", 32'(periph_en), 32'd1);
  endtask

  task automatic t_wide_high();
    do_reset(1'b1, 1'b0);
    wr(8'h44, 16'h8000);
    check("R7 high base shut_up", 32'(shut_up), 32'd1);
    check("R7 high base flag", 32'(hi_base_flag), 32'd1);
    check("R7 high base not configured", 32'(configured), 32'd0);
    check("R10 periph off when shut", 32'(periph_en), 32'd0);
    check("R11 chain when shut", 32'(chain_out), 32'd1);
    rd_silent(8'h04, "R9 read after auto shutup");
    wr(8'h44, 16'h1000);
    check("R12 shut stays after base", 32'(configured), 32'd0);
  endtask

  task automatic t_narrow_high();
    do_reset(1'b0, 1'b0);
    wr(8'h48, 16'h0080);
    check("R7 narrow 0x80 configures", 32'(configured), 32'd1);
    check("R7 narrow no flag", 32'(hi_base_flag), 32'd0);
    check("R7 narrow base", 32'(base_addr), 32'h0080);
  endtask

  task automatic t_shutup();
    do_reset(1'b0, 1'b0);
    wr(8'h4C, 16'h0000);
    check("R8 shutup command", 32'(shut_up), 32'd1);
    check("R8 shutup no flag", 32'(hi_base_flag), 32'd0);
    check("R11 chain after shutup", 32'(chain_out), 32'd1);
    wr(8'h48, 16'h0033);
    check("R8 base after shutup ignored", 32'(configured), 32'd0);
    check("R10 periph after shutup", 32'(periph_en), 32'd0);
    rd_silent(8'h10, "R9 read after shutup");
    do_reset(1'b0, 1'b0);
    check("R12 reset clears shut", 32'(shut_up), 32'd0);
    rd(8'h00, 4'hC, "R9 readable after reset");
  endtask

  initial begin
    t_reset_state();
    t_ids_narrow();
    t_ids_wide();
    t_jumper();
    t_narrow_cfg();
    t_wide_cfg();
    t_wide_high();
    t_narrow_high();
    t_shutup();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule